// File: doc/BRIEF.md
# Mesh Wormhole Router with Dimension-Order Routing

A five-port flit router for one tile of a regular two-dimensional mesh. It has one port towards each of its four neighbours (North, South, East, West) and a Local port to the cluster attached to the tile. A link carries one 34-bit flit per cycle. A flit is a 32-bit payload plus two framing bits that mark the first and the last flit of a packet. Flow control is FIFO-style: the sender raises a write strobe together with the flit, and the receiver answers in the same cycle with a write-ok that says whether the flit was taken.

Each input has a small flit buffer. The header flit carries a 4-bit destination Y and a 4-bit destination X. The router compares them with its own coordinates and sends the packet along X first, then along Y, then out on Local. An output is granted to one input for a whole packet, from the header to the flit marked last (wormhole switching). When several headers compete for a free output, a round-robin arbiter picks one of them. A flit that arrives outside a packet is discarded and raises a sticky error flag.

Top module: `meshRouter`

## Requirements
- R1: A flit is 34 bits: bit 33 marks the first flit of a packet (begin), bit 32 marks the last flit (end), and bits 31:0 are the payload. In a header, bits 31:28 hold the destination Y and bits 27:24 hold the destination X. Port indices are Local=0, North=1, South=2, East=3, West=4. Flit k of each port occupies bits k*34+33 : k*34 of the flat flit buses.
- R2: A header whose X is greater than the router's X (parameter MY_X) leaves on East. A header whose X is smaller leaves on West. This holds whatever its Y is.
- R3: A header whose X equals MY_X leaves on North if its Y is greater than MY_Y, on South if its Y is smaller, and on Local if the Y values are equal.
- R4: A flit written on an idle input during cycle c is presented on its output during cycle c+1. An output that is not stalled passes one flit per cycle.
- R5: Once an input is granted an output, that output carries only flits of that input until the flit marked end has been taken. A header from another input waits until then.
- R6: Headers that contend for the same free output are served in round-robin order. The pointer moves past the winner when the winner's end flit leaves, so two inputs that each keep sending single-flit packets alternate.
- R7: Each input buffers up to FIFO_DEPTH (default 4) flits. Its write-ok is low while the buffer is full. A flit written while write-ok is low is ignored. Flits leave an output in the order in which they were accepted.
- R8: A flit leaves an output only in a cycle where both outWr and outWrOk are high. While outWrOk is low, outWr stays high and the flit on that output does not change.
- R9: A flit that reaches the head of an input without the begin bit, while that input holds no output, is discarded without appearing on any output. It sets errFlag, which stays set until reset.
- R10: Reset (rstN low, asynchronous) empties all buffers and releases all outputs. It leaves outWr at zero, every inWrOk at one and errFlag at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inWr | input | 5 | Write strobe for each input port |
| inFlit | input | 170 | Input flits, 34 bits per port |
| inWrOk | output | 5 | Input buffer can accept the flit this cycle |
| outWr | output | 5 | Flit presented on each output port |
| outFlit | output | 170 | Output flits, 34 bits per port |
| outWrOk | input | 5 | Downstream takes the presented flit this cycle |
| errFlag | output | 1 | Sticky flag for a discarded out-of-packet flit |

## Verification
The bench sends headers whose X and Y differ in both directions at once. A router that resolved Y first would send such packets North or South instead of East or West. It stalls an output while a second input queues a header behind an unfinished packet. Interleaving on that output shows that the lock is released too early or never taken. Two inputs queue single-flit packets for one output. A fixed-priority arbiter drains one input before the other instead of alternating. Other tests fill an input buffer and offer one more flit while write-ok is low, check that a stalled flit stays stable, and send a flit without the begin bit. A router that dropped, duplicated or reordered flits, or that forwarded the stray flit, shows it in the captured output sequence.

// File: rtl/meshRouterPkg.sv
package meshRouterPkg;
  localparam int NPORTS    = 5;
  localparam int PAYLOAD_W = 32;
  localparam int FLIT_W    = PAYLOAD_W + 2;
  localparam int COORD_W   = 4;
  localparam int PSEL_W    = $clog2(NPORTS);
  localparam int BOP_BIT   = FLIT_W - 1;
  localparam int EOP_BIT   = FLIT_W - 2;
  localparam int Y_LSB     = PAYLOAD_W - COORD_W;
  localparam int X_LSB     = PAYLOAD_W - 2 * COORD_W;

  localparam logic [PSEL_W-1:0] PORT_LOCAL = 3'd0;
  localparam logic [PSEL_W-1:0] PORT_NORTH = 3'd1;
  localparam logic [PSEL_W-1:0] PORT_SOUTH = 3'd2;
  localparam logic [PSEL_W-1:0] PORT_EAST  = 3'd3;
  localparam logic [PSEL_W-1:0] PORT_WEST  = 3'd4;

  typedef struct packed {
    logic [NPORTS-1:0]             pop;
    logic [NPORTS-1:0]             drive;
    logic [NPORTS-1:0][PSEL_W-1:0] sel;
  } ctlStrobes_t;

  function automatic logic [PSEL_W-1:0] portWrap(logic [PSEL_W-1:0] base, int step);
    int s;
    s = int'(base) + step;
    if (s >= NPORTS) s = s - NPORTS;
    return PSEL_W'(s);
  endfunction

  function automatic logic [PSEL_W-1:0] xFirstRoute(logic [FLIT_W-1:0] f,
                                                    logic [COORD_W-1:0] myX,
                                                    logic [COORD_W-1:0] myY);
    logic [COORD_W-1:0] dy;
    logic [COORD_W-1:0] dx;
    dy = f[Y_LSB +: COORD_W];
    dx = f[X_LSB +: COORD_W];
    if (dx > myX)      return PORT_EAST;
    else if (dx < myX) return PORT_WEST;
    else if (dy > myY) return PORT_NORTH;
    else if (dy < myY) return PORT_SOUTH;
    else               return PORT_LOCAL;
  endfunction
endpackage

// File: rtl/meshFlitFifo.sv
module meshFlitFifo #(
  parameter int WIDTH = 34,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] head,
  output logic             notEmpty,
  output logic             notFull
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [AW-1:0]    rdIdx, wrIdx;
  logic [CW-1:0]    fill;
  logic             doPush, doPop;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign notEmpty = (fill != '0);
  assign notFull  = (fill != CW'(DEPTH));
  assign doPush   = push & notFull;
  assign doPop    = pop & notEmpty;
  assign head     = slots[rdIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdIdx <= '0;
      wrIdx <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrIdx <= bump(wrIdx);
      if (doPop)  rdIdx <= bump(rdIdx);
      fill <= fill + CW'(doPush) - CW'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) slots[wrIdx] <= din;
  end
endmodule

// File: rtl/meshRouterDp.sv
module meshRouterDp
  import meshRouterPkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NPORTS-1:0]             inWr,
  input  logic [NPORTS-1:0][FLIT_W-1:0] inFlit,
  output logic [NPORTS-1:0]             inWrOk,
  input  ctlStrobes_t                   strobes,
  output logic [NPORTS-1:0]             headValid,
  output logic [NPORTS-1:0][FLIT_W-1:0] headFlit,
  output logic [NPORTS-1:0]             outWr,
  output logic [NPORTS-1:0][FLIT_W-1:0] outFlit
);
  for (genvar g = 0; g < NPORTS; g++) begin : g_in
    meshFlitFifo #(.WIDTH(FLIT_W), .DEPTH(FIFO_DEPTH)) uFifo (
      .clk      (clk),
      .rstN     (rstN),
      .push     (inWr[g]),
      .pop      (strobes.pop[g]),
      .din      (inFlit[g]),
      .head     (headFlit[g]),
      .notEmpty (headValid[g]),
      .notFull  (inWrOk[g])
    );
  end

  for (genvar g = 0; g < NPORTS; g++) begin : g_out
    assign outFlit[g] = headFlit[strobes.sel[g]];
    assign outWr[g]   = strobes.drive[g];
  end
endmodule

// File: rtl/meshRouterCtl.sv
module meshRouterCtl
  import meshRouterPkg::*;
#(
  parameter logic [COORD_W-1:0] MY_X = 4'd2,
  parameter logic [COORD_W-1:0] MY_Y = 4'd2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NPORTS-1:0]             headValid,
  input  logic [NPORTS-1:0][FLIT_W-1:0] headFlit,
  input  logic [NPORTS-1:0]             outWrOk,
  output ctlStrobes_t                   strobes,
  output logic                          errFlag
);
  logic [NPORTS-1:0]             inBusy, outBusy;
  logic [NPORTS-1:0][PSEL_W-1:0] outOwner, rrPtr, route, srcSel, winner;
  logic [NPORTS-1:0]             wantNew, dropNow, anyReq, drv, xfer, xferEop;
  logic [NPORTS-1:0]             inGrant, inXfer, inXferEop;
  logic                          errQ;

  always_comb begin
    // route computation on each input head (R2, R3)
    for (int i = 0; i < NPORTS; i++) begin
      route[i]   = xFirstRoute(headFlit[i], MY_X, MY_Y);
      wantNew[i] = headValid[i] & ~inBusy[i] & headFlit[i][BOP_BIT];
      dropNow[i] = headValid[i] & ~inBusy[i] & ~headFlit[i][BOP_BIT];
    end
    // per-output allocation: owner when locked, round-robin winner otherwise
    for (int o = 0; o < NPORTS; o++) begin
      winner[o] = rrPtr[o];
      anyReq[o] = 1'b0;
      for (int k = NPORTS - 1; k >= 0; k--) begin
        if (wantNew[portWrap(rrPtr[o], k)] &&
            route[portWrap(rrPtr[o], k)] == PSEL_W'(o)) begin
          winner[o] = portWrap(rrPtr[o], k);
          anyReq[o] = 1'b1;
        end
      end
      srcSel[o]  = outBusy[o] ? outOwner[o] : winner[o];
      drv[o]     = outBusy[o] ? headValid[outOwner[o]] : anyReq[o];
      xfer[o]    = drv[o] & outWrOk[o];
      xferEop[o] = headFlit[srcSel[o]][EOP_BIT];
    end
    // fold output decisions back onto inputs
    for (int i = 0; i < NPORTS; i++) begin
      inGrant[i]   = 1'b0;
      inXfer[i]    = 1'b0;
      inXferEop[i] = 1'b0;
      for (int o = 0; o < NPORTS; o++) begin
        if (drv[o] && srcSel[o] == PSEL_W'(i)) begin
          inGrant[i]   = 1'b1;
          inXfer[i]    = xfer[o];
          inXferEop[i] = xferEop[o];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inBusy   <= '0;
      outBusy  <= '0;
      outOwner <= '0;
      rrPtr    <= '0;
      errQ     <= 1'b0;
    end else begin
      for (int o = 0; o < NPORTS; o++) begin
        if (xfer[o] && xferEop[o]) begin
          outBusy[o] <= 1'b0;
          rrPtr[o]   <= portWrap(srcSel[o], 1);
        end else if (drv[o]) begin
          outBusy[o]  <= 1'b1;
          outOwner[o] <= srcSel[o];
        end
      end
      for (int i = 0; i < NPORTS; i++) begin
        if (inGrant[i]) inBusy[i] <= ~(inXfer[i] & inXferEop[i]);
      end
      if (|dropNow) errQ <= 1'b1;
    end
  end

  assign strobes.pop   = inXfer | dropNow;
  assign strobes.drive = drv;
  assign strobes.sel   = srcSel;
  assign errFlag       = errQ;
endmodule

// File: rtl/meshRouter.sv
module meshRouter
  import meshRouterPkg::*;
#(
  parameter logic [COORD_W-1:0] MY_X       = 4'd2,
  parameter logic [COORD_W-1:0] MY_Y       = 4'd2,
  parameter int                 FIFO_DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NPORTS-1:0]        inWr,
  input  logic [NPORTS*FLIT_W-1:0] inFlit,
  output logic [NPORTS-1:0]        inWrOk,
  output logic [NPORTS-1:0]        outWr,
  output logic [NPORTS*FLIT_W-1:0] outFlit,
  input  logic [NPORTS-1:0]        outWrOk,
  output logic                     errFlag
);
  logic [NPORTS-1:0][FLIT_W-1:0] inFlitV, outFlitV, headFlit;
  logic [NPORTS-1:0]             headValid;
  ctlStrobes_t                   ctlS;

  assign inFlitV = inFlit;
  assign outFlit = outFlitV;

  meshRouterDp #(.FIFO_DEPTH(FIFO_DEPTH)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .inWr      (inWr),
    .inFlit    (inFlitV),
    .inWrOk    (inWrOk),
    .strobes   (ctlS),
    .headValid (headValid),
    .headFlit  (headFlit),
    .outWr     (outWr),
    .outFlit   (outFlitV)
  );

  meshRouterCtl #(.MY_X(MY_X), .MY_Y(MY_Y)) uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .headValid (headValid),
    .headFlit  (headFlit),
    .outWrOk   (outWrOk),
    .strobes   (ctlS),
    .errFlag   (errFlag)
  );
endmodule

// File: rtl/meshRouterChk.sv
module meshRouterChk
  import meshRouterPkg::*;
#(
  parameter int DEPTH = 4
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NPORTS-1:0]        inWr,
  input logic [NPORTS-1:0]        inWrOk,
  input logic [NPORTS-1:0]        outWr,
  input logic [NPORTS-1:0]        outWrOk,
  input logic [NPORTS*FLIT_W-1:0] outFlit,
  input logic                     errFlag,
  input logic [NPORTS-1:0]        popVec,
  input logic [NPORTS*PSEL_W-1:0] selVec
);
  localparam int OW = $clog2(DEPTH + 2);

  // occupancy seen from the port handshake and the control pop strobes
  logic [NPORTS-1:0][OW-1:0] occ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) occ <= '0;
    else begin
      for (int i = 0; i < NPORTS; i++)
        occ[i] <= occ[i] + OW'(inWr[i] & inWrOk[i]) - OW'(popVec[i]);
    end
  end

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
      occ[g] <= OW'(DEPTH));

    assert_full_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
      (occ[g] == OW'(DEPTH)) |-> !inWrOk[g]);

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
      (outWr[g] && !outWrOk[g]) |=>
        (outWr[g] && $stable(outFlit[g*FLIT_W +: FLIT_W])));

    assert_lock_held_R5: assert property (@(posedge clk) disable iff (!rstN)
      (outWr[g] && outWrOk[g] && !outFlit[g*FLIT_W + EOP_BIT]) |=>
        (selVec[g*PSEL_W +: PSEL_W] == $past(selVec[g*PSEL_W +: PSEL_W])));
  end

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  assert_reset_clear_R10: assert property (@(posedge clk)
    !rstN |=> (outWr == '0 && !errFlag));
endmodule

bind meshRouter meshRouterChk #(.DEPTH(FIFO_DEPTH)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .inWr    (inWr),
  .inWrOk  (inWrOk),
  .outWr   (outWr),
  .outWrOk (outWrOk),
  .outFlit (outFlit),
  .errFlag (errFlag),
  .popVec  (ctlS.pop),
  .selVec  (ctlS.sel)
);

// File: tb/meshRouter_test.sv
module meshRouter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 5;
  localparam int FW = 34;
  localparam int P_L = 0, P_N = 1, P_S = 2, P_E = 3, P_W = 4;
  localparam int NVEC = 12;
  localparam int WATCHDOG = 5000;
  // {src, destY, destX, expected output}; router sits at X=2, Y=2
  localparam logic [15:0] ROUTE_VEC [NVEC] = '{
    16'h0253, 16'h0204, 16'h3721, 16'h4022, 16'h1220, 16'h2993,
    16'h3914, 16'h4F21, 16'h1122, 16'h2220, 16'h0220, 16'h0321
  };

  logic             clk = 1'b0;
  logic             rstN;
  logic [NP-1:0]    inWr, inWrOk, outWr, outWrOk;
  logic [NP*FW-1:0] inFlit, outFlit;
  logic             errFlag;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  int cyc     = 0;
  logic [FW-1:0] logFlit [NP][64];
  int            logCyc  [NP][64];
  int            logCnt  [NP] = '{default: 0};

  meshRouter uut (
    .clk(clk), .rstN(rstN), .inWr(inWr), .inFlit(inFlit), .inWrOk(inWrOk),
    .outWr(outWr), .outFlit(outFlit), .outWrOk(outWrOk), .errFlag(errFlag)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // capture every completed output transfer
  always @(posedge clk) begin
    cyc++;
    for (int o = 0; o < NP; o++) begin
      if (outWr[o] && outWrOk[o] && logCnt[o] < 64) begin
        logFlit[o][logCnt[o]] = outFlit[o*FW +: FW];
        logCyc[o][logCnt[o]]  = cyc;
        logCnt[o]++;
      end
    end
  end

  function automatic logic [FW-1:0] mkFlit(logic b, logic e, logic [3:0] y,
                                           logic [3:0] x, logic [23:0] tag);
    return {b, e, y, x, tag};
  endfunction

  task automatic checkVal(input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic putFlit(input int p, input logic [FW-1:0] f);
    inWr[p] = 1'b1;
    inFlit[p*FW +: FW] = f;
  endtask

  task automatic stepIdle(input int n);
    for (int k = 0; k < n; k++) begin
      inWr = '0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] wh, wb, wt, lh, lt, f;
    int base;
    inWr = '0; inFlit = '0; outWrOk = '1; rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    checkVal("R10 outWr in reset", 64'(outWr), 64'h0);
    checkVal("R10 inWrOk in reset", 64'(inWrOk), 64'h1f);
    checkVal("R10 errFlag in reset", 64'(errFlag), 64'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R1, R2, R3, R4: table of single-flit packets, one-cycle latency
    for (int v = 0; v < NVEC; v++) begin
      int src, ex;
      src = int'(ROUTE_VEC[v][15:12]);
      ex  = int'(ROUTE_VEC[v][3:0]);
      f   = mkFlit(1'b1, 1'b1, ROUTE_VEC[v][11:8], ROUTE_VEC[v][7:4], 24'hA00 + 24'(v));
      inWr = '0;
      putFlit(src, f);
      @(negedge clk);
      inWr = '0;
      checkVal($sformatf("R2/R3 vec %0d outWr", v), 64'(outWr), 64'(5'b1 << ex));
      checkVal($sformatf("R1/R4 vec %0d flit", v), 64'(outFlit[ex*FW +: FW]), 64'(f));
      @(negedge clk);
    end

    // R5: wormhole lock, Local header waits behind West packet on East
    base = logCnt[P_E];
    wh = mkFlit(1, 0, 4'd2, 4'd5, 24'h111);
    wb = mkFlit(0, 0, 4'd2, 4'd5, 24'h112);
    wt = mkFlit(0, 1, 4'd2, 4'd5, 24'h113);
    lh = mkFlit(1, 0, 4'd2, 4'd6, 24'h221);
    lt = mkFlit(0, 1, 4'd2, 4'd6, 24'h222);
    inWr = '0; putFlit(P_W, wh); @(negedge clk);
    inWr = '0; putFlit(P_W, wb); putFlit(P_L, lh); @(negedge clk);
    inWr = '0; putFlit(P_W, wt); putFlit(P_L, lt); outWrOk[P_E] = 1'b0;
    checkVal("R5 East carries West body", 64'(outFlit[P_E*FW +: FW]), 64'(wb));
    @(negedge clk);
    inWr = '0;
    @(negedge clk);
    checkVal("R8 stalled East still valid", 64'(outWr[P_E]), 64'h1);
    checkVal("R8 stalled East flit stable", 64'(outFlit[P_E*FW +: FW]), 64'(wb));
    outWrOk[P_E] = 1'b1;
    stepIdle(8);
    checkVal("R5 East flit count", 64'(logCnt[P_E] - base), 64'd5);
    checkVal("R5 East order 0", 64'(logFlit[P_E][base]),   64'(wh));
    checkVal("R5 East order 1", 64'(logFlit[P_E][base+1]), 64'(wb));
    checkVal("R5 East order 2", 64'(logFlit[P_E][base+2]), 64'(wt));
    checkVal("R5 East order 3", 64'(logFlit[P_E][base+3]), 64'(lh));
    checkVal("R5 East order 4", 64'(logFlit[P_E][base+4]), 64'(lt));

    // R6: North and South contend for Local, must alternate
    outWrOk[P_L] = 1'b0;
    base = logCnt[P_L];
    inWr = '0;
    putFlit(P_N, mkFlit(1, 1, 4'd2, 4'd2, 24'd1));
    putFlit(P_S, mkFlit(1, 1, 4'd2, 4'd2, 24'd2));
    @(negedge clk);
    inWr = '0;
    putFlit(P_N, mkFlit(1, 1, 4'd2, 4'd2, 24'd3));
    putFlit(P_S, mkFlit(1, 1, 4'd2, 4'd2, 24'd4));
    @(negedge clk);
    stepIdle(2);
    outWrOk[P_L] = 1'b1;
    stepIdle(8);
    checkVal("R6 Local flit count", 64'(logCnt[P_L] - base), 64'd4);
    begin
      logic [23:0] t0, t1, t2, t3;
      logic ok;
      t0 = logFlit[P_L][base][23:0];
      t1 = logFlit[P_L][base+1][23:0];
      t2 = logFlit[P_L][base+2][23:0];
      t3 = logFlit[P_L][base+3][23:0];
      ok = (t0 == 1 && t1 == 2 && t2 == 3 && t3 == 4) ||
           (t0 == 2 && t1 == 1 && t2 == 4 && t3 == 3);
      checkVal($sformatf("R6 alternation %0d,%0d,%0d,%0d", t0, t1, t2, t3), 64'(ok), 64'h1);
    end
    checkVal("R4 Local drains one per cycle",
             64'(logCyc[P_L][base+3] - logCyc[P_L][base]), 64'd3);

    // R7: fill East input while West output stalls, offer one refused flit
    outWrOk[P_W] = 1'b0;
    base = logCnt[P_W];
    for (int k = 0; k < 4; k++) begin
      inWr = '0;
      putFlit(P_E, mkFlit(k == 0, k == 3, 4'd2, 4'd0, 24'h300 + 24'(k)));
      @(negedge clk);
    end
    inWr = '0;
    checkVal("R7 full input drops write-ok", 64'(inWrOk), 64'b10111);
    putFlit(P_E, mkFlit(0, 0, 4'd2, 4'd0, 24'hBAD));
    @(negedge clk);
    inWr = '0;
    checkVal("R8 stalled West flit", 64'(outFlit[P_W*FW +: FW]),
             64'(mkFlit(1, 0, 4'd2, 4'd0, 24'h300)));
    outWrOk[P_W] = 1'b1;
    stepIdle(8);
    checkVal("R7 refused flit ignored, count", 64'(logCnt[P_W] - base), 64'd4);
    for (int k = 0; k < 4; k++)
      checkVal($sformatf("R7 West order %0d", k), 64'(logFlit[P_W][base+k]),
               64'(mkFlit(k == 0, k == 3, 4'd2, 4'd0, 24'h300 + 24'(k))));
    checkVal("R4 West back-to-back", 64'(logCyc[P_W][base+3] - logCyc[P_W][base]), 64'd3);
    checkVal("R7 write-ok restored", 64'(inWrOk), 64'h1f);

    // R9: out-of-packet flit is dropped and flags an error
    checkVal("R9 errFlag clear before", 64'(errFlag), 64'h0);
    inWr = '0;
    putFlit(P_S, mkFlit(0, 1, 4'd2, 4'd2, 24'h55));
    @(negedge clk);
    inWr = '0;
    checkVal("R9 stray flit not forwarded", 64'(outWr), 64'h0);
    @(negedge clk);
    checkVal("R9 errFlag set", 64'(errFlag), 64'h1);
    f = mkFlit(1, 1, 4'd2, 4'd2, 24'h56);
    putFlit(P_S, f);
    @(negedge clk);
    inWr = '0;
    checkVal("R9 next packet still routed", 64'(outWr), 64'(5'b1 << P_L));
    @(negedge clk);
    checkVal("R9 errFlag sticky", 64'(errFlag), 64'h1);

    // R10: reset clears the sticky flag
    rstN = 1'b0;
    @(negedge clk);
    checkVal("R10 errFlag cleared by reset", 64'(errFlag), 64'h0);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule